// File: doc/BRIEF.md
# Flash Octal DDR Mode Switch Sequencer

This block moves an attached serial NOR flash between plain single-wire SPI operation and an octal double-data-rate mode that uses a data strobe. It keeps a register holding the mode the flash is in now. When a mode change is requested, it sends a short series of command frames to a frame engine. Each frame carries an opcode, an address, an address byte count, an optional data byte and a bus-mode flag. The engine accepts a frame with a ready pulse and later reports completion with a done pulse and an error bit.

Octal DDR is entered with a write enable followed by a write to the flash's volatile configuration. The only way back to SPI is a two-command soft reset, sent in octal DDR, with a timed pause after each command. The pause is at least one microsecond and is counted in clock cycles derived from a frequency parameter.

After a switch completes without error, the block commits the new mode and loads the matching read parameters that a read engine consumes: opcode, dummy cycles, address width and protocol. An error from the engine ends the sequence at once, keeps the old mode and parameters, and raises an error flag.

Top module: `fms_mode_switch`

## Requirements
- R1: After reset the current mode is SPI (`cur_mode_o`=0), the read parameters are opcode 0x0C, 8 dummy cycles, 4 address bytes and single-wire protocol (`rd_octal_o`=0), and `frm_valid_o`, `done_o` and `err_o` are low.
- R2: A request whose target equals the current mode emits no frame, and `done_o` is high for one cycle in the cycle right after the request cycle.
- R3: A switch from SPI to octal DDR (`req_mode_i`=1) emits exactly two frames, both with `frm_dtr_o`=0. The first is opcode 0x06 with 0 address bytes and no data. The second is opcode 0x81 with address 0, 3 address bytes, `frm_has_data_o`=1 and data 0xE7.
- R4: A switch from octal DDR to SPI (`req_mode_i`=0) emits exactly two frames, both with `frm_dtr_o`=1, 0 address bytes and no data. The first has opcode 0x66 and the second has opcode 0x99.
- R5: After the done of each reset frame, neither a new frame nor `done_o` appears for at least GAP_CYC = ceil(CLK_FREQ_HZ / 1 MHz) cycles.
- R6: After a successful entry to octal DDR, `cur_mode_o`=1 and the read parameters are opcode 0xFD, 16 dummy cycles, 4 address bytes and `rd_octal_o`=1.
- R7: After a successful return to SPI, `cur_mode_o`=0 and the read parameters are opcode 0x0C, 8 dummy cycles, 4 address bytes and `rd_octal_o`=0.
- R8: If a done arrives with `frm_err_i`=1, no further frame is issued, `done_o` rises with `err_o`=1, and the mode and read parameters keep their old values. `err_o` is cleared when the next request is accepted.
- R9: A frame is offered one at a time. While `frm_valid_o` is high and `frm_ready_i` is low, the valid and all frame fields hold. No new frame is offered before the previous frame's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Mode change request, sampled only while idle |
| req_mode_i | input | 1 | Target mode: 0 SPI, 1 octal DDR |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last switch failed |
| cur_mode_o | output | 1 | Committed current mode |
| frm_valid_o | output | 1 | Frame offered to engine |
| frm_ready_i | input | 1 | Engine takes the frame |
| frm_opcode_o | output | 8 | Frame opcode |
| frm_addr_o | output | 32 | Frame address |
| frm_addr_bytes_o | output | 3 | Address byte count |
| frm_has_data_o | output | 1 | Frame carries one data byte |
| frm_data_o | output | 8 | Data byte |
| frm_dtr_o | output | 1 | 1 octal DDR framing, 0 single-wire |
| frm_done_i | input | 1 | Engine finished the frame |
| frm_err_i | input | 1 | Error, valid with done |
| rd_opcode_o | output | 8 | Read opcode for the read engine |
| rd_dummy_o | output | 5 | Read dummy cycles |
| rd_addr_bytes_o | output | 3 | Read address bytes |
| rd_octal_o | output | 1 | Read protocol octal on all phases |

## Verification
The bench sets CLK_FREQ_HZ to 25 MHz, which makes the post-reset pause 25 cycles. At that length, dozens of return trips to SPI fit in a short run, and the pause can still be measured exactly against the frame engine's own done pulses. Random engine latencies and random error injection reach errors on every frame position in both directions. Directed cases pin down same-mode requests and errors on the first and second frames.

// File: rtl/fms_pkg.sv
package fms_pkg;
  typedef enum logic {MODE_SPI = 1'b0, MODE_ODTR = 1'b1} fms_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_GAP, S_DONE
  } fms_state_e;

  localparam int unsigned FMS_ADDR_W = 32;

  localparam logic [7:0] OP_WREN      = 8'h06;
  localparam logic [7:0] OP_WR_VOLCFG = 8'h81;
  localparam logic [7:0] OP_RST_EN    = 8'h66;
  localparam logic [7:0] OP_RST_MEM   = 8'h99;
  localparam logic [7:0] OP_RD_SPI    = 8'h0C;
  localparam logic [7:0] OP_RD_ODTR   = 8'hFD;
  localparam logic [7:0] VOLCFG_ODTR  = 8'hE7;

  typedef struct packed {
    logic [7:0]            opcode;
    logic [FMS_ADDR_W-1:0] addr;
    logic [2:0]            addr_bytes;
    logic                  has_data;
    logic [7:0]            data;
    logic                  dtr;
  } fms_frame_t;

  typedef struct packed {
    logic [7:0] opcode;
    logic [4:0] dummy;
    logic [2:0] addr_bytes;
    logic       octal;
  } fms_rdp_t;
endpackage

// File: rtl/fms_frame_table.sv
module fms_frame_table
  import fms_pkg::*;
(
  input  fms_mode_e  tgt_i,
  input  logic       step_i,
  output fms_frame_t frame_o
);
  always_comb begin
    frame_o = '0;
    if (tgt_i == MODE_ODTR) begin
      frame_o.dtr = 1'b0;
      if (!step_i) begin
        frame_o.opcode = OP_WREN;
      end else begin
        frame_o.opcode     = OP_WR_VOLCFG;
        frame_o.addr_bytes = 3'd3;
        frame_o.has_data   = 1'b1;
        frame_o.data       = VOLCFG_ODTR;
      end
    end else begin
      frame_o.dtr    = 1'b1;
      frame_o.opcode = step_i ? OP_RST_MEM : OP_RST_EN;
    end
  end
endmodule

// File: rtl/fms_gap_timer.sv
module fms_gap_timer #(
  parameter int unsigned GAP_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = CW'(GAP_CYC);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == CW'(1));

  // R5: the pause is never restarted while one is still running
  assert_gap_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q == '0));
endmodule

// File: rtl/fms_read_params.sv
module fms_read_params
  import fms_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  fms_mode_e mode_i,
  output fms_rdp_t  rdp_o
);
  fms_rdp_t rdp_q, rdp_d;

  always_comb begin
    rdp_d            = rdp_q;
    rdp_d.addr_bytes = 3'd4;
    if (mode_i == MODE_ODTR) begin
      rdp_d.opcode = OP_RD_ODTR;
      rdp_d.dummy  = 5'd16;
      rdp_d.octal  = 1'b1;
    end else begin
      rdp_d.opcode = OP_RD_SPI;
      rdp_d.dummy  = 5'd8;
      rdp_d.octal  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdp_q.opcode     <= OP_RD_SPI;
      rdp_q.dummy      <= 5'd8;
      rdp_q.addr_bytes <= 3'd4;
      rdp_q.octal      <= 1'b0;
    end else if (load_i) begin
      rdp_q <= rdp_d;
    end
  end

  assign rdp_o = rdp_q;
endmodule

// File: rtl/fms_mode_switch.sv
module fms_mode_switch
  import fms_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        req_mode_i,
  output logic        done_o,
  output logic        err_o,
  output logic        cur_mode_o,
  output logic        frm_valid_o,
  input  logic        frm_ready_i,
  output logic [7:0]  frm_opcode_o,
  output logic [31:0] frm_addr_o,
  output logic [2:0]  frm_addr_bytes_o,
  output logic        frm_has_data_o,
  output logic [7:0]  frm_data_o,
  output logic        frm_dtr_o,
  input  logic        frm_done_i,
  input  logic        frm_err_i,
  output logic [7:0]  rd_opcode_o,
  output logic [4:0]  rd_dummy_o,
  output logic [2:0]  rd_addr_bytes_o,
  output logic        rd_octal_o
);
  localparam int unsigned GAP_RAW = (CLK_FREQ_HZ + 999_999) / 1_000_000;
  localparam int unsigned GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam logic        LAST_STEP = 1'b1;

  fms_state_e state_q, state_d;
  fms_mode_e  mode_q, mode_d, tgt_q, tgt_d;
  logic       step_q, step_d;
  logic       err_q, err_d;
  logic       go_commit, tmr_load, tmr_exp, seq_en;
  fms_frame_t frame;
  fms_rdp_t   rdp;

  fms_frame_table u_table (
    .tgt_i   (tgt_q),
    .step_i  (step_q),
    .frame_o (frame)
  );

  fms_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .expired_o (tmr_exp)
  );

  fms_read_params u_rdp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go_commit),
    .mode_i (tgt_q),
    .rdp_o  (rdp)
  );

  always_comb begin
    state_d   = state_q;
    tgt_d     = tgt_q;
    step_d    = step_q;
    err_d     = err_q;
    mode_d    = mode_q;
    go_commit = 1'b0;
    tmr_load  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_i) begin
          err_d = 1'b0;
          if (fms_mode_e'(req_mode_i) == mode_q) begin
            state_d = S_DONE;
          end else begin
            tgt_d   = fms_mode_e'(req_mode_i);
            step_d  = 1'b0;
            state_d = S_ISSUE;
          end
        end
      end
      S_ISSUE: begin
        if (frm_ready_i) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (frm_done_i) begin
          if (frm_err_i) begin
            err_d   = 1'b1;
            state_d = S_DONE;
          end else if (tgt_q == MODE_SPI) begin
            tmr_load = 1'b1;
            state_d  = S_GAP;
          end else if (step_q == LAST_STEP) begin
            go_commit = 1'b1;
            state_d   = S_DONE;
          end else begin
            step_d  = 1'b1;
            state_d = S_ISSUE;
          end
        end
      end
      S_GAP: begin
        if (tmr_exp) begin
          if (step_q == LAST_STEP) begin
            go_commit = 1'b1;
            state_d   = S_DONE;
          end else begin
            step_d  = 1'b1;
            state_d = S_ISSUE;
          end
        end
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (go_commit) mode_d = tgt_q;
  end

  assign seq_en = (state_d != state_q) || (state_q == S_IDLE && req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tgt_q   <= MODE_SPI;
      step_q  <= 1'b0;
      err_q   <= 1'b0;
      mode_q  <= MODE_SPI;
    end else if (seq_en) begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      step_q  <= step_d;
      err_q   <= err_d;
      mode_q  <= mode_d;
    end
  end

  assign done_o           = (state_q == S_DONE);
  assign err_o            = err_q;
  assign cur_mode_o       = mode_q;
  assign frm_valid_o      = (state_q == S_ISSUE);
  assign frm_opcode_o     = frame.opcode;
  assign frm_addr_o       = frame.addr;
  assign frm_addr_bytes_o = frame.addr_bytes;
  assign frm_has_data_o   = frame.has_data;
  assign frm_data_o       = frame.data;
  assign frm_dtr_o        = frame.dtr;
  assign rd_opcode_o      = rdp.opcode;
  assign rd_dummy_o       = rdp.dummy;
  assign rd_addr_bytes_o  = rdp.addr_bytes;
  assign rd_octal_o       = rdp.octal;

  // R9: an offered frame holds until the engine takes it
  assert_frame_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && !frm_ready_i) |=> (frm_valid_o && $stable(frm_opcode_o)
      && $stable(frm_addr_o) && $stable(frm_data_o) && $stable(frm_dtr_o)));

  // R9: after acceptance nothing new is offered in the next cycle
  assert_one_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && frm_ready_i) |=> !frm_valid_o);

  // R8: an engine error leaves the mode untouched and flags the failure
  assert_err_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && frm_done_i && frm_err_i) |=>
      (cur_mode_o == $past(cur_mode_o)) && err_o && done_o);

  // R6: octal DDR mode always pairs with the octal read setup
  assert_odtr_params_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_mode_o |-> (rd_opcode_o == 8'hFD && rd_dummy_o == 5'd16 && rd_octal_o));

  // R7: SPI mode always pairs with the single-wire read setup
  assert_spi_params_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_mode_o |-> (rd_opcode_o == 8'h0C && rd_dummy_o == 5'd8 && !rd_octal_o));

  // R2: completion is never signalled while a frame is on offer
  assert_done_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !frm_valid_o);
endmodule

// File: tb/fms_mode_switch_tb_top.sv
module fms_mode_switch_tb_top;
  localparam int unsigned FREQ    = 25_000_000;
  localparam int          GAP_EXP = 25;

  logic        clk, rst_n;
  logic        req, req_mode;
  logic        done_o, err_o, cur_mode;
  logic        frm_valid, frm_ready, frm_done, frm_err;
  logic [7:0]  frm_opcode, frm_data;
  logic [31:0] frm_addr;
  logic [2:0]  frm_ab;
  logic        frm_hd, frm_dtr;
  logic [7:0]  rd_op;
  logic [4:0]  rd_dummy;
  logic [2:0]  rd_ab;
  logic        rd_oct;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  logic [7:0]  r_op   [0:3];
  logic [31:0] r_addr [0:3];
  logic [2:0]  r_ab   [0:3];
  logic        r_hd   [0:3];
  logic [7:0]  r_dat  [0:3];
  logic        r_dtr  [0:3];
  int rec_n  = 0;
  int err_at = -1;
  int force_err = -1;  // -1 none, -2 random, else frame index
  logic exp_mode = 1'b0;

  fms_mode_switch #(.CLK_FREQ_HZ(FREQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_mode_i(req_mode),
    .done_o(done_o), .err_o(err_o), .cur_mode_o(cur_mode),
    .frm_valid_o(frm_valid), .frm_ready_i(frm_ready),
    .frm_opcode_o(frm_opcode), .frm_addr_o(frm_addr),
    .frm_addr_bytes_o(frm_ab), .frm_has_data_o(frm_hd),
    .frm_data_o(frm_data), .frm_dtr_o(frm_dtr),
    .frm_done_i(frm_done), .frm_err_i(frm_err),
    .rd_opcode_o(rd_op), .rd_dummy_o(rd_dummy),
    .rd_addr_bytes_o(rd_ab), .rd_octal_o(rd_oct)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // expected frame fields: t = target mode, i = frame index
  function automatic logic [7:0] e_op(input logic t, input int i);
    if (t) return (i == 0) ? 8'h06 : 8'h81;
    return (i == 0) ? 8'h66 : 8'h99;
  endfunction
  function automatic logic [2:0] e_ab(input logic t, input int i);
    return (t && i == 1) ? 3'd3 : 3'd0;
  endfunction
  function automatic logic e_hd(input logic t, input int i);
    return t && i == 1;
  endfunction

  // frame engine model
  initial begin
    frm_ready = 0; frm_done = 0; frm_err = 0;
    forever begin
      @(negedge clk);
      if (frm_valid) begin
        logic inj;
        int   cnt;
        logic was_dtr;
        repeat ($urandom % 3) @(negedge clk);
        if (rec_n < 4) begin
          r_op[rec_n] = frm_opcode; r_addr[rec_n] = frm_addr;
          r_ab[rec_n] = frm_ab; r_hd[rec_n] = frm_hd;
          r_dat[rec_n] = frm_data; r_dtr[rec_n] = frm_dtr;
        end
        was_dtr = frm_dtr;
        frm_ready = 1;
        @(negedge clk);
        frm_ready = 0;
        chk(!frm_valid, "R9", "valid dropped after accept", frm_valid, 0);
        repeat (1 + $urandom % 3) begin
          @(negedge clk);
          chk(!frm_valid, "R9", "no frame before done", frm_valid, 0);
        end
        if (force_err == -2) inj = ($urandom % 8 == 0);
        else inj = (force_err == rec_n);
        if (inj) err_at = rec_n;
        rec_n++;
        frm_done = 1; frm_err = inj;
        @(negedge clk);
        frm_done = 0; frm_err = 0;
        if (was_dtr && !inj) begin
          cnt = 0;
          while (!frm_valid && !done_o) begin
            @(negedge clk);
            cnt++;
          end
          chk(cnt >= GAP_EXP, "R5", "pause after reset frame", cnt, GAP_EXP);
        end
      end
    end
  end

  task automatic check_params(input string rq);
    chk(cur_mode == exp_mode, rq, "current mode", cur_mode, exp_mode);
    chk(rd_op == (exp_mode ? 8'hFD : 8'h0C), rq, "read opcode", rd_op,
        exp_mode ? 8'hFD : 8'h0C);
    chk(rd_dummy == (exp_mode ? 5'd16 : 5'd8), rq, "dummy cycles", rd_dummy,
        exp_mode ? 16 : 8);
    chk(rd_ab == 3'd4, rq, "read address bytes", rd_ab, 4);
    chk(rd_oct == exp_mode, rq, "read protocol", rd_oct, exp_mode);
  endtask

  task automatic do_switch(input logic t, input int ferr);
    bit   same;
    int   n_exp;
    logic nm;
    string rq;
    same = (t == exp_mode);
    force_err = ferr; rec_n = 0; err_at = -1;
    @(negedge clk);
    req = 1; req_mode = t;
    @(negedge clk);
    req = 0;
    if (same) chk(done_o == 1'b1, "R2", "done one cycle after request", done_o, 1);
    while (!done_o) @(negedge clk);
    if (same) n_exp = 0;
    else if (err_at >= 0) n_exp = err_at + 1;
    else n_exp = 2;
    rq = same ? "R2" : (t ? "R3" : "R4");
    chk(rec_n == n_exp, rq, "frame count", rec_n, n_exp);
    for (int i = 0; i < rec_n && i < 4; i++) begin
      chk(r_op[i] == e_op(t, i), rq, "opcode", r_op[i], e_op(t, i));
      chk(r_addr[i] == 32'd0, rq, "address", r_addr[i], 0);
      chk(r_ab[i] == e_ab(t, i), rq, "address bytes", r_ab[i], e_ab(t, i));
      chk(r_hd[i] == e_hd(t, i), rq, "has data", r_hd[i], e_hd(t, i));
      if (e_hd(t, i)) chk(r_dat[i] == 8'hE7, rq, "data byte", r_dat[i], 8'hE7);
      chk(r_dtr[i] == !t, rq, "bus mode", r_dtr[i], !t);
    end
    chk(err_o == (err_at >= 0), "R8", "error flag", err_o, err_at >= 0);
    nm = (err_at >= 0) ? exp_mode : t;
    exp_mode = nm;
    check_params((err_at >= 0) ? "R8" : (t ? "R6" : "R7"));
    @(negedge clk);
    chk(done_o == 1'b0, "R2", "done is one cycle", done_o, 0);
    force_err = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    req = 0; req_mode = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(frm_valid == 0, "R1", "valid in reset", frm_valid, 0);
    chk(done_o == 0 && err_o == 0, "R1", "done/err in reset", {done_o, err_o}, 0);
    check_params("R1");
    rst_n = 1;
    @(negedge clk);
    // directed corner cases
    do_switch(1'b0, -1);   // R2 same mode SPI
    do_switch(1'b1, -1);   // R3 R6 entry
    do_switch(1'b1, -1);   // R2 same mode octal
    do_switch(1'b0, -1);   // R4 R5 R7 exit
    do_switch(1'b1, 1);    // R8 error on configuration write
    do_switch(1'b1, 0);    // R8 error on write enable
    do_switch(1'b1, -1);   // R8 flag clears on next request
    do_switch(1'b0, 0);    // R8 error on first reset frame
    do_switch(1'b0, 1);    // R8 error on second reset frame
    do_switch(1'b0, -1);
    // random mix
    for (int k = 0; k < 60; k++) do_switch(1'($urandom % 2), -2);
    finish_run();
  end
endmodule